// File: doc/BRIEF.md
# Serial Audio Input Rate Classifier

This block sorts an incoming biphase-mark audio line into one of seven sample-rate classes (32000, 44100, 48000, 88200, 96000, 176400 and 192000 Hz, codes 0 to 6). The line first passes through a two-flop synchronizer into the fast reference-clock domain. The block then counts, in reference cycles, the gap between each pair of consecutive transitions and keeps the shortest gap seen during a measurement window whose length is programmable.

When a window closes, twice the shortest gap is compared against six programmable thresholds. Software sets each threshold to the sum of the timer values of two neighbouring rate classes, where a timer is the reference frequency over 128 times the class rate. The window is normally set to one millisecond of reference cycles. The result is published in a registered status word. A sticky interrupt flag is raised when the class changes, and a masked interrupt line is driven from the flags.

Top module: `spdif_rate_detect`

## Requirements
- R1: After reset the status word reports class code 7, a width of 0 and all eight flags clear, and the interrupt output is low.
- R2: The width field (status bits 17:8) reports the smallest number of reference cycles between two consecutive line transitions recorded in the last closed window.
- R3: With w the reported width and T[i] the threshold of class i, the class code (status bits 30:28) is 1 + the largest i in 0..5 with 2*w <= T[i], or 0 when 2*w exceeds T[0].
- R4: A window in which no transition gap was recorded reports class code 7 and width 0.
- R5: The class and width fields change only when a window of `win_len_i` reference cycles closes.
- R6: Flag bit 2 (status bit 2) is set when a closing window changes the class code, and it stays set until cleared.
- R7: A change from class 7 to class 0 does not set flag bit 2.
- R8: Writing a one to a bit of `irq_clr_i` clears that flag on the next cycle, unless it is set again in the same cycle.
- R9: `irq_o` is high exactly when some flag bit and the same bit of `irq_mask_i` are both set.
- R10: While `en_i` is low, no window closes and the status fields keep their values.
- R11: The thresholds are 10-bit fields, three per 32-bit word of `thr_words_i`. Word 0 holds classes 0, 1 and 2 at bits 29:20, 19:10 and 9:0. Word 1, at bits 63:32, holds classes 3, 4 and 5 in the same order.
- R12: A transition gap longer than 1023 cycles is measured as 1023.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable for measurement |
| line_i | input | 1 | Asynchronous biphase-mark audio line |
| win_len_i | input | 20 | Window length in reference cycles |
| thr_words_i | input | 64 | Packed class thresholds |
| irq_mask_i | input | 8 | Per-flag interrupt enable |
| irq_clr_i | input | 8 | Write-one-to-clear pulses for the flags |
| status_o | output | 32 | Class code, width and flags |
| irq_o | output | 1 | Masked combined interrupt |

## Verification
The assertions assume that the reset is held for at least one clock before operation. They also assume that a clear pulse for flag bit 2 does not land in the same cycle as a window close, because a fresh set wins in that cycle. The stimulus raises clear pulses only several windows after any rate change, when no further class change can be pending. Window length and thresholds are changed only between measurement phases. A window is always long enough to hold at least two transitions of the rate being tested, except on purpose in the no-signal and saturation cases.

// File: rtl/srd_pkg.sv
package srd_pkg;
  localparam int          MODE_W       = 3;
  localparam logic [2:0]  MODE_NONE    = 3'd7;
  localparam int          IRQ_MODE_BIT = 2;
  localparam int          STAT_MODE_LO = 28;
  localparam int          STAT_W_LO    = 8;
  localparam int          WORD_W       = 32;
endpackage

// File: rtl/srd_sync_edge.sv
module srd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign edge_o = sync_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/srd_width_meter.sv
module srd_width_meter #(
  parameter int MEAS_W = 10,
  parameter int WIN_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              edge_i,
  input  logic [WIN_W-1:0]  win_len_i,
  output logic              win_end_o,
  output logic              meas_valid_o,
  output logic [MEAS_W-1:0] meas_width_o
);
  localparam logic [MEAS_W-1:0] SAT = '1;

  logic [MEAS_W-1:0] run_q, min_q, min_nx;
  logic              armed_q, got_q, got_nx, rec;
  logic [WIN_W-1:0]  win_q, win_last;

  assign win_last  = (win_len_i == '0) ? '0 : win_len_i - 1'b1;
  assign win_end_o = en_i && (win_q >= win_last);
  assign rec       = en_i && edge_i && armed_q;

  always_comb begin
    min_nx = min_q;
    got_nx = got_q;
    if (rec) begin
      got_nx = 1'b1;
      if (!got_q || run_q < min_q) min_nx = run_q;
    end
  end

  assign meas_valid_o = got_nx;
  assign meas_width_o = got_nx ? min_nx : '0;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      run_q   <= '0;
      armed_q <= 1'b0;
      min_q   <= SAT;
      got_q   <= 1'b0;
      win_q   <= '0;
    end else begin
      if (edge_i) begin
        run_q   <= MEAS_W'(1);
        armed_q <= 1'b1;
      end else if (run_q != SAT) begin
        run_q <= run_q + 1'b1;
      end
      if (win_end_o) begin
        win_q <= '0;
        min_q <= SAT;
        got_q <= 1'b0;
      end else begin
        win_q <= win_q + 1'b1;
        min_q <= min_nx;
        got_q <= got_nx;
      end
    end
  end

  // R2
  min_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    got_q |-> (min_q != '0));
endmodule

// File: rtl/srd_mode_ladder.sv
module srd_mode_ladder #(
  parameter int N_MODES  = 7,
  parameter int MEAS_W   = 10,
  parameter int THR_W    = 10,
  parameter int PER_WORD = 3,
  parameter int WORD_W   = 32,
  parameter int N_WORDS  = 2
) (
  input  logic [MEAS_W-1:0]         width_i,
  input  logic [N_WORDS*WORD_W-1:0] thr_words_i,
  output logic [2:0]                mode_o
);
  localparam int N_THR = N_MODES - 1;
  localparam int CW    = (MEAS_W + 1 > THR_W) ? MEAS_W + 1 : THR_W;

  logic [CW-1:0]    dbl;
  logic [N_THR-1:0] le;

  assign dbl = CW'({width_i, 1'b0});

  for (genvar gi = 0; gi < N_THR; gi++) begin : g_thr
    localparam int WORD = gi / PER_WORD;
    localparam int POS  = PER_WORD - 1 - (gi % PER_WORD);
    localparam int LSB  = WORD * WORD_W + POS * THR_W;
    logic [THR_W-1:0] thr;
    assign thr    = thr_words_i[LSB +: THR_W];
    assign le[gi] = dbl <= CW'(thr);
  end

  always_comb begin
    mode_o = '0;
    for (int i = 0; i < N_THR; i++)
      if (le[i]) mode_o = 3'(i + 1);
  end
endmodule

// File: rtl/spdif_rate_detect.sv
module spdif_rate_detect
  import srd_pkg::*;
#(
  parameter int N_MODES  = 7,
  parameter int MEAS_W   = 10,
  parameter int WIN_W    = 20,
  parameter int THR_W    = 10,
  parameter int PER_WORD = 3,
  parameter int N_IRQ    = 8,
  parameter int SYNC_N   = 2,
  parameter int N_WORDS  = (N_MODES - 1 + PER_WORD - 1) / PER_WORD
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en_i,
  input  logic                      line_i,
  input  logic [WIN_W-1:0]          win_len_i,
  input  logic [N_WORDS*WORD_W-1:0] thr_words_i,
  input  logic [N_IRQ-1:0]          irq_mask_i,
  input  logic [N_IRQ-1:0]          irq_clr_i,
  output logic [WORD_W-1:0]         status_o,
  output logic                      irq_o
);
  logic              edge_s, win_end, meas_valid;
  logic [MEAS_W-1:0] meas_w;
  logic [2:0]        ladder_mode, new_mode;
  logic              chg;
  logic [N_IRQ-1:0]  flags_nx;

  logic [2:0]        mode_q;
  logic [MEAS_W-1:0] width_q;
  logic [N_IRQ-1:0]  flags_q;
  logic              irq_q;

  srd_sync_edge #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .line_i(line_i), .edge_o(edge_s)
  );

  srd_width_meter #(.MEAS_W(MEAS_W), .WIN_W(WIN_W)) u_meter (
    .clk(clk), .rst(rst), .en_i(en_i), .edge_i(edge_s),
    .win_len_i(win_len_i), .win_end_o(win_end),
    .meas_valid_o(meas_valid), .meas_width_o(meas_w)
  );

  srd_mode_ladder #(
    .N_MODES(N_MODES), .MEAS_W(MEAS_W), .THR_W(THR_W),
    .PER_WORD(PER_WORD), .WORD_W(WORD_W), .N_WORDS(N_WORDS)
  ) u_ladder (
    .width_i(meas_w), .thr_words_i(thr_words_i), .mode_o(ladder_mode)
  );

  always_comb begin
    new_mode = meas_valid ? ladder_mode : MODE_NONE;
    chg = win_end && (new_mode != mode_q) &&
          !(mode_q == MODE_NONE && new_mode == 3'd0);
    flags_nx = flags_q & ~irq_clr_i;
    if (chg) flags_nx[IRQ_MODE_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_NONE;
      width_q <= '0;
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_nx;
      irq_q   <= |(flags_nx & irq_mask_i);
      if (win_end) begin
        mode_q  <= new_mode;
        width_q <= meas_w;
      end
    end
  end

  always_comb begin
    status_o = '0;
    status_o[STAT_MODE_LO +: MODE_W] = mode_q;
    status_o[STAT_W_LO +: MEAS_W]    = width_q;
    status_o[N_IRQ-1:0]              = flags_q;
  end
  assign irq_o = irq_q;

  // R4
  no_signal_width_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_NONE) |-> (width_q == '0));
  // R5
  window_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> ($stable(mode_q) && $stable(width_q)));
  // R6
  flag_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_q[IRQ_MODE_BIT]) |-> (mode_q != $past(mode_q)));
  // R7
  no_flag_none_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_q[IRQ_MODE_BIT]) |-> !($past(mode_q) == MODE_NONE && mode_q == 3'd0));
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_clr_i[IRQ_MODE_BIT] && !win_end) |=> !flags_q[IRQ_MODE_BIT]);
endmodule

// File: tb/spdif_rate_detect_bench.sv
module spdif_rate_detect_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 200;
  localparam int WDOG       = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        line = 1'b0;
  logic [19:0] win_len = 20'(WIN);
  logic [63:0] thr_words;
  logic [7:0]  mask = 8'h04;
  logic [7:0]  clr = 8'h00;
  logic [31:0] status;
  logic        irq;

  int per = 0;
  int tcnt = 0;
  int total = 0;
  int fails = 0;
  bit done = 0;
  int thr[6] = '{140, 113, 83, 56, 41, 27};

  always #(CLK_PERIOD/2) clk = ~clk;

  assign thr_words = {2'b00, 10'd56, 10'd41, 10'd27, 2'b00, 10'd140, 10'd113, 10'd83};

  spdif_rate_detect u_spdif_rate_detect (
    .clk(clk), .rst(rst), .en_i(en), .line_i(line), .win_len_i(win_len),
    .thr_words_i(thr_words), .irq_mask_i(mask), .irq_clr_i(clr),
    .status_o(status), .irq_o(irq)
  );

  always @(negedge clk) begin
    if (per != 0) begin
      if (tcnt >= per - 1) begin line <= ~line; tcnt <= 0; end
      else tcnt <= tcnt + 1;
    end
  end

  function automatic int exp_mode(int k);
    int w = (k > 1023) ? 1023 : k;
    int m = 0;
    for (int i = 0; i < 6; i++) if (2 * w <= thr[i]) m = i + 1;
    return m;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wcyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags();
    clr = 8'hFF;
    wcyc(1);
    clr = 8'h00;
    wcyc(2);
  endtask

  initial begin
    int prev;
    int m;
    wcyc(3);
    rst = 1'b0;
    wcyc(2);
    // R1 reset state
    chk("R1 mode", int'(status[30:28]), 7);
    chk("R1 width", int'(status[17:8]), 0);
    chk("R1 flags", int'(status[7:0]), 0);
    chk("R1 irq", int'(irq), 0);

    // R4 enabled, no transitions
    en = 1'b1;
    wcyc(3 * WIN + 5);
    chk("R4 mode", int'(status[30:28]), 7);
    chk("R4 width", int'(status[17:8]), 0);
    chk("R4 flags", int'(status[7:0]), 0);

    // R2 R3 R6 R8 R11 sweep of transition spacings
    prev = 7;
    for (int k = 4; k <= 100; k++) begin
      per = k;
      wcyc(3 * WIN + 5);
      m = exp_mode(k);
      chk("R2 width", int'(status[17:8]), k);
      chk("R3 R11 mode", int'(status[30:28]), m);
      chk("R6 flag", int'(status[2]), (m != prev) ? 1 : 0);
      chk("R9 irq", int'(irq), (m != prev) ? 1 : 0);
      clear_flags();
      chk("R8 cleared", int'(status[7:0]), 0);
      prev = m;
    end

    // R5 a long window holds the old class after the line stops
    win_len = 20'd1000;
    wcyc(2 * 1000);
    clear_flags();
    per = 0;
    wcyc(900);
    chk("R5 hold mode", int'(status[30:28]), 0);
    chk("R5 hold width", int'(status[17:8]), 100);
    wcyc(1200);
    chk("R5 R4 late mode", int'(status[30:28]), 7);
    chk("R6 flag to none", int'(status[2]), 1);
    clear_flags();
    win_len = 20'(WIN);

    // R7 none to class 0 raises no flag
    per = 80;
    wcyc(3 * WIN + 5);
    chk("R7 mode", int'(status[30:28]), 0);
    chk("R7 flag", int'(status[2]), 0);
    chk("R7 irq", int'(irq), 0);

    // R9 mask gating
    mask = 8'h00;
    per = 13;
    wcyc(3 * WIN + 5);
    chk("R3 mode 6", int'(status[30:28]), 6);
    chk("R6 flag set", int'(status[2]), 1);
    chk("R9 masked irq", int'(irq), 0);
    mask = 8'hFB;
    wcyc(3);
    chk("R9 other bits irq", int'(irq), 0);
    mask = 8'h04;
    wcyc(3);
    chk("R9 enabled irq", int'(irq), 1);
    clear_flags();
    chk("R8 irq low", int'(irq), 0);
    chk("R8 flag low", int'(status[2]), 0);

    // R10 disabled measurement keeps status
    en = 1'b0;
    per = 80;
    wcyc(4 * WIN);
    chk("R10 mode", int'(status[30:28]), 6);
    chk("R10 width", int'(status[17:8]), 13);
    chk("R10 flag", int'(status[2]), 0);
    en = 1'b1;
    wcyc(4 * WIN);
    chk("R10 resumed mode", int'(status[30:28]), 0);
    chk("R10 resumed width", int'(status[17:8]), 80);
    chk("R6 resumed flag", int'(status[2]), 1);
    clear_flags();

    // R12 saturation of long gaps
    win_len = 20'd3000;
    per = 1100;
    wcyc(4 * 3000);
    chk("R12 width", int'(status[17:8]), 1023);
    chk("R12 mode", int'(status[30:28]), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", WDOG, 0);
      $display("  [TB] %0d tests run, %0d failed", total, fails);
      $finish;
    end
  end
endmodule